// File: doc/BRIEF.md
# Serial memory page-write engine

This block is the device side of a small serial memory that takes a page-write command over a four-wire serial link. While the select line is low, the engine shifts in three things: an instruction byte, a 16-bit address and one or more data bytes. Each data byte goes into a 32-byte page buffer. Successive bytes go to successive offsets in the page, and the offset wraps inside the page.

When the select line returns high, the engine checks the whole command. If every condition holds, the buffered bytes are copied into the internal byte array. A self-timed write cycle then runs for a fixed number of system clocks, and the busy flag is high for that time. If any condition fails, the command is dropped silently. The engine then pulses a clear request for the external write-enable latch. The same request is pulsed when a write cycle ends.

The serial inputs are synchronised into the system clock domain and sampled there. The bytes in the array can be read through a plain combinational read port.

Top module: `spi_page_writer`

## Requirements
- R1: Bits on `sdi` are taken on each rising edge of `sck` while `cs_n` is low, most significant bit first. The first byte is the instruction, and the write instruction is 0x02. The next two bytes are the address, high byte first. Each further byte is a data byte, stored at the current address.
- R2: After each data byte, address bits [4:0] advance by one and wrap from 31 to 0. The bits above them stay fixed, so a write never leaves the addressed 32-byte page.
- R3: If more than 32 data bytes are sent, later bytes overwrite the bytes loaded earlier at the same offsets. Offsets that received no byte keep their old contents.
- R4: A command is committed only if `cs_n` rises after a whole number of bytes and after at least one data byte. A rise that comes mid-byte, or right after the address, writes nothing. An instruction other than 0x02 writes nothing.
- R5: On commit, `busy` goes to 1 on the third rising `clk` edge after `cs_n` rises. It stays at 1 for exactly `WC_CYCLES` clocks and then returns to 0.
- R6: If `wen_latch` was 0 when `cs_n` fell, the command writes nothing and `busy` stays at 0.
- R7: If `busy` was 1 when `cs_n` fell, the command writes nothing.
- R8: `prot_bits` is sampled when `cs_n` rises. It rejects a command based on address bits [ADDR_W-1:ADDR_W-2], as follows:
  - 00 rejects nothing.
  - 01 rejects a command whose two bits are 11.
  - 10 rejects a command whose upper bit is 1.
  - 11 rejects every command.
- R9: Address bits at and above `ADDR_W` are ignored. With the default `ADDR_W` of 10, address 0xFC20 writes to location 0x020.
- R10: `wen_clear` pulses high for one clock on two occasions: in the clock where `busy` falls, and two clocks after `cs_n` rises on a rejected command whose instruction was 0x02. No other command produces a pulse.
- R11: After reset, `busy` and `wen_clear` are 0 and every array byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| wen_latch | input | 1 | Current state of the external write-enable latch |
| prot_bits | input | 2 | Block-protect setting |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` (combinational) |
| busy | output | 1 | Write cycle in progress |
| wen_clear | output | 1 | One-clock request to clear the write-enable latch |

## Verification
Every serial input passes through two synchronising flops before the engine acts on it. As a result, `busy` rises on the third clock edge after `cs_n` rises: the bench samples at the falling edge after the second edge, expecting 0, and after the third, expecting 1. The bench then counts falling edges while `busy` stays high and expects exactly `WC_CYCLES`. Array contents are due from the third edge onward, but the bench compares the whole 32-byte page against its model only after `busy` has dropped, and likewise checks the `wen_clear` pulse count only once the command has settled, so neither check depends on an exact edge.

// File: rtl/spi_page_writer.sv
module spi_page_writer #(
  parameter int ADDR_W    = 10,
  parameter int WC_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic              wen_latch,
  input  logic [1:0]        prot_bits,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              wen_clear
);
  localparam int PAGE_W = 5;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CNT_W  = $clog2(WC_CYCLES + 1);
  localparam logic [7:0] OP_WRITE = 8'h02;

  logic [2:0] cs_q, sck_q;
  logic [1:0] sd_q;
  logic [6:0] sh;
  logic [7:0] op;
  logic [2:0] bit_idx;
  logic [1:0] byte_cnt;
  logic       have_data, wel_ok, busy_s;
  logic [ADDR_W-1:0] addr;
  logic [7:0] pbuf [PAGE_N];
  logic [PAGE_N-1:0] vmask;
  logic [7:0] mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic prot;

  wire cs_fall  = cs_q[2] & ~cs_q[1];
  wire cs_rise  = ~cs_q[2] & cs_q[1];
  wire sck_rise = sck_q[1] & ~sck_q[2] & ~cs_q[1];
  wire [7:0] nxt = {sh, sd_q[1]};
  wire [1:0] top2 = addr[ADDR_W-1 -: 2];

  always_comb begin
    case (prot_bits)
      2'b00: prot = 1'b0;
      2'b01: prot = (top2 == 2'b11);
      2'b10: prot = top2[1];
      default: prot = 1'b1;
    endcase
  end

  wire well_formed = (op == OP_WRITE) && (bit_idx == 3'd0) && have_data;
  wire commit = cs_rise && well_formed && wel_ok && !busy_s && !prot;
  wire reject = cs_rise && (op == OP_WRITE) && !commit;

  assign busy    = (cnt != '0);
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 3'b111;
      sck_q <= '0;
      sd_q  <= '0;
    end else begin
      cs_q  <= {cs_q[1:0], cs_n};
      sck_q <= {sck_q[1:0], sck};
      sd_q  <= {sd_q[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; op <= '0; bit_idx <= '0; byte_cnt <= '0;
      have_data <= 1'b0; wel_ok <= 1'b0; busy_s <= 1'b0;
      addr <= '0; vmask <= '0;
    end else if (cs_fall) begin
      op <= '0; bit_idx <= '0; byte_cnt <= '0;
      have_data <= 1'b0; vmask <= '0;
      wel_ok <= wen_latch;
      busy_s <= busy;
    end else if (sck_rise) begin
      sh      <= nxt[6:0];
      bit_idx <= bit_idx + 3'd1;
      if (bit_idx == 3'd7) begin
        if (byte_cnt != 2'd3) byte_cnt <= byte_cnt + 2'd1;
        case (byte_cnt)
          2'd0: op <= nxt;
          2'd1: addr[ADDR_W-1:8] <= nxt[ADDR_W-9:0];
          2'd2: addr[7:0] <= nxt;
          default: begin
            vmask[addr[PAGE_W-1:0]] <= 1'b1;
            addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
            have_data <= 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (sck_rise && bit_idx == 3'd7 && byte_cnt == 2'd3)
      pbuf[addr[PAGE_W-1:0]] <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      for (int i = 0; i < PAGE_N; i++)
        if (vmask[i]) mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      wen_clear <= 1'b0;
    end else begin
      wen_clear <= (cnt == CNT_W'(1)) | reject;
      if (commit) cnt <= CNT_W'(WC_CYCLES);
      else if (busy) cnt <= cnt - 1'b1;
    end
  end
endmodule

module spi_page_writer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       wen_clear,
  input logic       cs_rise,
  input logic       commit,
  input logic       wel_ok,
  input logic [1:0] prot_bits
);
  AST_BUSY_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(cs_rise)); // R5
  AST_CLEAR_AT_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> wen_clear); // R10
  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) wen_clear |=> !wen_clear); // R10
  AST_NO_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) commit |-> !busy); // R7
  AST_NO_COMMIT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) commit |-> wel_ok); // R6
  AST_NO_COMMIT_FULLPROT: assert property (@(posedge clk) disable iff (!rst_n) commit |-> prot_bits != 2'b11); // R8
endmodule

bind spi_page_writer spi_page_writer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wen_clear(wen_clear),
  .cs_rise(cs_rise), .commit(commit), .wel_ok(wel_ok), .prot_bits(prot_bits)
);

// File: tb/spi_page_writer_tb.sv
module spi_page_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int WC = 400;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, sdi = 0, wen_latch = 1;
  logic [1:0] prot_bits = 2'b00;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic busy, wen_clear;

  spi_page_writer #(.ADDR_W(AW), .WC_CYCLES(WC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .wen_latch(wen_latch), .prot_bits(prot_bits), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .wen_clear(wen_clear));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [AW-1:0] a; logic [7:0] d; string tag; } item_t;
  item_t q[$];
  logic [7:0] model [1 << AW];
  int errors = 0, checks = 0, clr_cnt = 0;

  always @(posedge clk) if (wen_clear) clr_cnt <= clr_cnt + 1;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdi = b[i];
      repeat (4) @(negedge clk);
      sck = 1;
      repeat (4) @(negedge clk);
      sck = 0;
    end
  endtask

  task automatic cmd(input logic [7:0] op, input logic [15:0] a, input int n,
                     input logic [7:0] seed, input int xbits, input bit ok);
    logic [4:0] off;
    off = a[4:0];
    @(negedge clk); cs_n = 0;
    repeat (4) @(negedge clk);
    send_bits(op, 8);
    send_bits(a[15:8], 8);
    send_bits(a[7:0], 8);
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      b = seed ^ 8'(k * 7);
      send_bits(b, 8);
      if (ok) model[{a[AW-1:5], off}] = b;
      off++;
    end
    if (xbits > 0) send_bits(8'hFF, xbits);
    repeat (4) @(negedge clk);
    cs_n = 1;
  endtask

  task automatic drain(input logic [AW-1:0] base, input string tag);
    for (int i = 0; i < 32; i++) begin
      item_t it;
      it.a = {base[AW-1:5], 5'(i)}; it.d = model[it.a]; it.tag = tag;
      q.push_back(it);
    end
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      rd_addr = it.a;
      #1;
      check(it.tag, rd_data, it.d);
    end
  endtask

  task automatic finish(input bit ok, input int exp_clr, input logic [AW-1:0] base, input string tag);
    int c0, n;
    c0 = clr_cnt;
    repeat (2) @(posedge clk); @(negedge clk);
    check({tag, " R5 busy not early"}, busy, 0);
    @(posedge clk); @(negedge clk);
    check({tag, " R5 busy start"}, busy, ok);
    if (ok) begin
      n = 0;
      while (busy === 1 && n < WC + 20) begin n++; @(negedge clk); end
      check({tag, " R5 busy length"}, n, WC);
    end
    repeat (5) @(negedge clk);
    check({tag, " R10 clear pulses"}, clr_cnt - c0, exp_clr);
    drain(base, tag);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) model[i] = 0;
    repeat (5) @(negedge clk);
    check("R11 busy reset", busy, 0);
    check("R11 clear reset", wen_clear, 0);
    rst_n = 1;
    drain(10'h000, "R11 array reset");

    cmd(8'h02, 16'h0043, 1, 8'hA5, 0, 1); finish(1, 1, 10'h040, "R1 single byte");
    cmd(8'h02, 16'h005E, 4, 8'h3C, 0, 1); finish(1, 1, 10'h040, "R2 page wrap");
    cmd(8'h02, 16'h0080, 34, 8'h11, 0, 1); finish(1, 1, 10'h080, "R3 overwrite");
    cmd(8'h02, 16'h00A2, 2, 8'h77, 4, 0); finish(0, 1, 10'h0A0, "R4 mid-byte");
    cmd(8'h02, 16'h00C0, 0, 8'h00, 0, 0); finish(0, 1, 10'h0C0, "R4 no data");
    cmd(8'h03, 16'h00E0, 2, 8'h55, 0, 0); finish(0, 0, 10'h0E0, "R4 R10 other opcode");
    wen_latch = 0;
    cmd(8'h02, 16'h0100, 2, 8'h66, 0, 0); finish(0, 1, 10'h100, "R6 latch low");
    wen_latch = 1;
    prot_bits = 2'b01;
    cmd(8'h02, 16'h03E0, 1, 8'h21, 0, 0); finish(0, 1, 10'h3E0, "R8 quarter hit");
    cmd(8'h02, 16'h0200, 1, 8'h22, 0, 1); finish(1, 1, 10'h200, "R8 quarter miss");
    prot_bits = 2'b10;
    cmd(8'h02, 16'h0220, 1, 8'h23, 0, 0); finish(0, 1, 10'h220, "R8 half hit");
    cmd(8'h02, 16'h0120, 1, 8'h24, 0, 1); finish(1, 1, 10'h120, "R8 half miss");
    prot_bits = 2'b11;
    cmd(8'h02, 16'h0000, 1, 8'h25, 0, 0); finish(0, 1, 10'h000, "R8 all");
    prot_bits = 2'b00;
    cmd(8'h02, 16'hFC20, 2, 8'h9E, 0, 1); finish(1, 1, 10'h020, "R9 upper bits");

    begin
      int c0;
      c0 = clr_cnt;
      cmd(8'h02, 16'h0160, 1, 8'h31, 0, 1);
      repeat (8) @(negedge clk);
      check("R7 busy before second", busy, 1);
      cmd(8'h02, 16'h0180, 1, 8'h32, 0, 0);
      while (busy === 1) @(negedge clk);
      repeat (5) @(negedge clk);
      check("R7 R10 clear pulses", clr_cnt - c0, 2);
      drain(10'h160, "R7 first page");
      drain(10'h180, "R7 second page");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule